// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the receive byte stream of an Ethernet MAC while the host has put the station into a low-power wake mode. While the mode bit is high, the block tells the receive path to stop delivering frames. It then inspects each incoming frame for a wake pattern.

A frame is only examined when its destination address is the station's own address or the all-ones broadcast address. The 6 destination bytes and the 6 source bytes are skipped. From byte 12 onward the block looks for a sync run of six 0xFF bytes, followed by the station address sent 16 times in a row. When the full pattern is seen, a sticky status bit is set. That bit can drive a host interrupt line, a power-management event line, or both, each behind its own enable. Frame check sequence validation is not part of this block.

Frames arrive one byte per clock, qualified by `rxValid`. `rxSof` marks the first byte of a frame and `rxEof` marks the last byte. A single byte may carry both marks.

Top module: `magic_wake_detect`

## Requirements
- R1: `rxBlock` is high in every cycle in which `modeEnable` is high. It is low whenever `modeEnable` is low, so normal reception resumes once the mode bit is cleared.
- R2: A frame is searched only when its first six bytes equal the station address or are all 0xFF (broadcast). A frame with any other destination never sets the status.
- R3: Bytes at frame offsets 0 to 11 take no part in the pattern search. This holds even when they contain 0xFF bytes or copies of the station address.
- R4: Six consecutive 0xFF bytes, followed immediately by the six station address bytes repeated 16 times, set `wakeStatus`. The status is set on the clock edge that samples the last address byte. A run of more than six 0xFF bytes before the first address byte is still a valid sync.
- R5: A sync run of only five 0xFF bytes does not set the status. Fifteen address repeats followed by a different byte do not set the status either.
- R6: A byte that breaks the sequence restarts the search. If the breaking byte is 0xFF, it counts as the first byte of a new sync run. The search continues to the end of the frame.
- R7: Station address bytes are matched in wire order. The first byte sent is `stationAddr[7:0]` and the sixth is `stationAddr[47:40]`. The same address sent with its byte order reversed does not match.
- R8: `wakeStatus` stays set until a cycle with `statusClear` high clears it. When a detection and a clear happen in the same cycle, the status ends up set.
- R9: `hostIrq` equals `wakeStatus` AND `irqEnable`. `pmeEvent` equals `wakeStatus` AND `pmeEnable`.
- R10: No frame sets the status while `modeEnable` is low. Each `rxSof` restarts the frame and search state. Valid bytes that arrive outside a frame (after `rxEof` and before the next `rxSof`) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | A receive byte is present this cycle |
| rxData | input | 8 | Receive byte |
| rxSof | input | 1 | The byte is the first of a frame |
| rxEof | input | 1 | The byte is the last of a frame |
| stationAddr | input | 48 | Station address; bits 7:0 are sent first |
| modeEnable | input | 1 | Wake detection mode on |
| irqEnable | input | 1 | Let the status drive the host interrupt |
| pmeEnable | input | 1 | Let the status drive the power event |
| statusClear | input | 1 | Write-one-to-clear strobe for the status |
| rxBlock | output | 1 | Suppress normal frame delivery |
| wakeStatus | output | 1 | Sticky wake pattern received |
| hostIrq | output | 1 | Host interrupt request |
| pmeEvent | output | 1 | Power-management event |

## Verification
The assertions are checked on every cycle and cover the following:
- the status only rises after a cycle in wake mode, on a qualified frame, with the last address repeat in progress;
- the status only falls after a clear strobe, and it persists without one;
- the sync count stays within its bound;
- the header byte counter advances and saturates correctly.

Some behaviour is only shown by the bench scenarios, which compare every output against a behavioural model on each clock:
- destination filtering;
- skipping the header bytes;
- the exact sync and repeat counts;
- restart on a breaking 0xFF byte;
- byte order of the address;
- the set-over-clear priority.

// File: rtl/magic_wake_pkg.sv
package magic_wake_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic frameStart;   // current byte opens a new frame
    logic takeByte;     // current byte belongs to a frame
  } ctrlStrobes_t;

  // Compare results from the datapath to the control module.
  typedef struct packed {
    logic inPayload;    // current byte lies at offset 12 or later
    logic destOk;       // destination is own address or broadcast
    logic isFF;         // current byte is 0xFF
    logic matchExpect;  // current byte equals the selected address byte
    logic matchFirst;   // current byte equals the first address byte
  } dpStatus_t;

  typedef enum logic {
    PH_SYNC = 1'b0,
    PH_ADDR = 1'b1
  } searchPhase_t;

endpackage

// File: rtl/magic_wake_datapath.sv
module magic_wake_datapath
  import magic_wake_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [7:0]                    rxData,
  input  logic [8*ADDR_BYTES-1:0]       stationAddr,
  input  ctrlStrobes_t                  ctrl,
  input  logic [$clog2(ADDR_BYTES)-1:0] addrSel,
  output dpStatus_t                     stat
);

  localparam int HEADER_LEN = 2 * ADDR_BYTES;
  localparam int IDX_W      = $clog2(HEADER_LEN + 1);

  logic [7:0]       addrByte [ADDR_BYTES];
  logic [IDX_W-1:0] byteIdx;
  logic [IDX_W-1:0] curIdx;
  logic             inDest;
  logic             ownHit;
  logic             ownOk;
  logic             bcastOk;

  // Address bytes in wire order: the lowest byte goes out first.
  for (genvar gi = 0; gi < ADDR_BYTES; gi++) begin : g_addrByte
    assign addrByte[gi] = stationAddr[8*gi +: 8];
  end

  assign curIdx = ctrl.frameStart ? '0 : byteIdx;
  assign inDest = (curIdx < IDX_W'(ADDR_BYTES));

  always_comb begin
    ownHit = 1'b0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (curIdx == IDX_W'(i) && rxData == addrByte[i]) begin
        ownHit = 1'b1;
      end
    end
  end

  // Frame offset counter, saturating at the first payload offset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (ctrl.takeByte) begin
      if (curIdx == IDX_W'(HEADER_LEN)) begin
        byteIdx <= IDX_W'(HEADER_LEN);
      end else begin
        byteIdx <= curIdx + IDX_W'(1);
      end
    end
  end

  // Destination qualification, built byte by byte.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownOk   <= 1'b0;
      bcastOk <= 1'b0;
    end else if (ctrl.takeByte && inDest) begin
      if (ctrl.frameStart) begin
        ownOk   <= ownHit;
        bcastOk <= (rxData == 8'hFF);
      end else begin
        ownOk   <= ownOk & ownHit;
        bcastOk <= bcastOk & (rxData == 8'hFF);
      end
    end
  end

  assign stat.inPayload   = (curIdx == IDX_W'(HEADER_LEN));
  assign stat.destOk      = ownOk | bcastOk;
  assign stat.isFF        = (rxData == 8'hFF);
  assign stat.matchExpect = (rxData == addrByte[addrSel]);
  assign stat.matchFirst  = (rxData == addrByte[0]);

  // R3: the offset counter never passes the header length.
  assert_idx_saturates_R3: assert property (@(posedge clk) disable iff (!rstN)
    byteIdx <= IDX_W'(HEADER_LEN));

  // R3: inside the header, each frame byte moves the offset by exactly one.
  assert_idx_steps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.takeByte && !ctrl.frameStart && byteIdx < IDX_W'(HEADER_LEN))
      |=> byteIdx == $past(byteIdx) + IDX_W'(1));

endmodule

// File: rtl/magic_wake_control.sv
module magic_wake_control
  import magic_wake_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          rxValid,
  input  logic                          rxSof,
  input  logic                          rxEof,
  input  logic                          modeEnable,
  input  logic                          statusClear,
  input  dpStatus_t                     stat,
  output ctrlStrobes_t                  ctrl,
  output logic [$clog2(ADDR_BYTES)-1:0] addrSel,
  output logic                          wakeStatus
);

  localparam int SEL_W = $clog2(ADDR_BYTES);
  localparam int FF_W  = $clog2(SYNC_LEN + 1);
  localparam int REP_W = $clog2(REPEATS);

  logic             inFrame;
  logic             searchByte;
  logic             detect;

  searchPhase_t     phase,    phaseNext;
  logic [FF_W-1:0]  ffCount,  ffCountNext;
  logic [SEL_W-1:0] addrIdx,  addrIdxNext;
  logic [REP_W-1:0] repCount, repCountNext;
  logic             found,    foundNext;

  // Framing: bytes count only from a start mark up to an end mark.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
    end else if (rxValid) begin
      if (rxEof) begin
        inFrame <= 1'b0;
      end else if (rxSof) begin
        inFrame <= 1'b1;
      end
    end
  end

  assign ctrl.frameStart = rxValid & rxSof;
  assign ctrl.takeByte   = rxValid & (rxSof | inFrame);

  assign searchByte = ctrl.takeByte & stat.inPayload & stat.destOk
                    & modeEnable & ~found;

  // Sync run and address repeat search.
  always_comb begin
    phaseNext    = phase;
    ffCountNext  = ffCount;
    addrIdxNext  = addrIdx;
    repCountNext = repCount;
    foundNext    = found;
    detect       = 1'b0;
    if (ctrl.frameStart) begin
      phaseNext    = PH_SYNC;
      ffCountNext  = '0;
      addrIdxNext  = '0;
      repCountNext = '0;
      foundNext    = 1'b0;
    end else if (searchByte) begin
      if (phase == PH_SYNC) begin
        if (ffCount == FF_W'(SYNC_LEN) && stat.matchFirst) begin
          phaseNext    = PH_ADDR;
          addrIdxNext  = SEL_W'(1);
          repCountNext = '0;
        end else if (stat.isFF) begin
          if (ffCount != FF_W'(SYNC_LEN)) begin
            ffCountNext = ffCount + FF_W'(1);
          end
        end else begin
          ffCountNext = '0;
        end
      end else begin
        if (stat.matchExpect) begin
          if (addrIdx == SEL_W'(ADDR_BYTES - 1)) begin
            addrIdxNext = '0;
            if (repCount == REP_W'(REPEATS - 1)) begin
              detect      = 1'b1;
              foundNext   = 1'b1;
              phaseNext   = PH_SYNC;
              ffCountNext = '0;
            end else begin
              repCountNext = repCount + REP_W'(1);
            end
          end else begin
            addrIdxNext = addrIdx + SEL_W'(1);
          end
        end else begin
          phaseNext   = PH_SYNC;
          addrIdxNext = '0;
          ffCountNext = stat.isFF ? FF_W'(1) : '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_SYNC;
      ffCount  <= '0;
      addrIdx  <= '0;
      repCount <= '0;
      found    <= 1'b0;
    end else begin
      phase    <= phaseNext;
      ffCount  <= ffCountNext;
      addrIdx  <= addrIdxNext;
      repCount <= repCountNext;
      found    <= foundNext;
    end
  end

  assign addrSel = addrIdx;

  // Sticky status: a detection wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeStatus <= 1'b0;
    end else if (detect) begin
      wakeStatus <= 1'b1;
    end else if (statusClear) begin
      wakeStatus <= 1'b0;
    end
  end

  // R8: without a clear strobe, a set status stays set.
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wakeStatus && !statusClear) |=> wakeStatus);

  // R8: the status only falls after a clear strobe.
  assert_status_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeStatus) |-> $past(statusClear));

  // R10: the status only rises after a byte seen in wake mode.
  assert_rise_needs_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeStatus) |-> $past(modeEnable));

  // R2: the status only rises on a qualified destination.
  assert_rise_needs_dest_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeStatus) |-> $past(stat.destOk));

  // R4: the status only rises while the last address repeat is in progress.
  assert_rise_on_last_repeat_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeStatus) |-> ($past(phase) == PH_ADDR && $past(repCount) == REP_W'(REPEATS - 1)));

  // R6: the sync counter stays within the run length.
  assert_sync_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    ffCount <= FF_W'(SYNC_LEN));

endmodule

// File: rtl/magic_wake_detect.sv
module magic_wake_detect
  import magic_wake_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxValid,
  input  logic [7:0]              rxData,
  input  logic                    rxSof,
  input  logic                    rxEof,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic                    modeEnable,
  input  logic                    irqEnable,
  input  logic                    pmeEnable,
  input  logic                    statusClear,
  output logic                    rxBlock,
  output logic                    wakeStatus,
  output logic                    hostIrq,
  output logic                    pmeEvent
);

  localparam int SEL_W = $clog2(ADDR_BYTES);

  ctrlStrobes_t     ctrl;
  dpStatus_t        stat;
  logic [SEL_W-1:0] addrSel;

  magic_wake_datapath #(
    .ADDR_BYTES(ADDR_BYTES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .rxData     (rxData),
    .stationAddr(stationAddr),
    .ctrl       (ctrl),
    .addrSel    (addrSel),
    .stat       (stat)
  );

  magic_wake_control #(
    .ADDR_BYTES(ADDR_BYTES),
    .SYNC_LEN  (SYNC_LEN),
    .REPEATS   (REPEATS)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .rxValid    (rxValid),
    .rxSof      (rxSof),
    .rxEof      (rxEof),
    .modeEnable (modeEnable),
    .statusClear(statusClear),
    .stat       (stat),
    .ctrl       (ctrl),
    .addrSel    (addrSel),
    .wakeStatus (wakeStatus)
  );

  assign rxBlock  = modeEnable;
  assign hostIrq  = wakeStatus & irqEnable;
  assign pmeEvent = wakeStatus & pmeEnable;

endmodule

// File: tb/magic_wake_detect_bench.sv
module magic_wake_detect_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        rxSof = 1'b0;
  logic        rxEof = 1'b0;
  logic [47:0] stationAddr = 48'h665544332211;
  logic        modeEnable = 1'b0;
  logic        irqEnable = 1'b0;
  logic        pmeEnable = 1'b0;
  logic        statusClear = 1'b0;
  logic        rxBlock, wakeStatus, hostIrq, pmeEvent;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural reference state
  bit   mInFrame = 0;
  int   mIdx = 0;
  bit   mOwn = 0;
  bit   mBcast = 0;
  int   mStage = 0;   // below 6: 0xFF run length; 6 and up: 6 + address bytes matched
  bit   mFound = 0;
  bit   expStatus = 0;

  logic [7:0] frameQ[$];

  always #5 clk = ~clk;

  magic_wake_detect u_magic_wake_detect (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxSof(rxSof), .rxEof(rxEof), .stationAddr(stationAddr),
    .modeEnable(modeEnable), .irqEnable(irqEnable), .pmeEnable(pmeEnable),
    .statusClear(statusClear), .rxBlock(rxBlock), .wakeStatus(wakeStatus),
    .hostIrq(hostIrq), .pmeEvent(pmeEvent)
  );

  function automatic logic [7:0] addrB(input logic [47:0] a, input int i);
    return a[8*i +: 8];
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R1", "rxBlock", rxBlock, modeEnable);
    check("R4", "wakeStatus", wakeStatus, expStatus);
    check("R9", "hostIrq", hostIrq, expStatus & irqEnable);
    check("R9", "pmeEvent", pmeEvent, expStatus & pmeEnable);
  endtask

  task automatic modelByte(input bit v, input logic [7:0] d, input bit s, input bit e, input bit clr);
    bit det = 0;
    if (v && (s || mInFrame)) begin
      if (s) begin
        mIdx = 0; mOwn = 1; mBcast = 1; mStage = 0; mFound = 0;
      end
      if (mIdx < 6) begin
        mOwn   = mOwn && (d == addrB(stationAddr, mIdx));
        mBcast = mBcast && (d == 8'hFF);
      end else if (mIdx >= 12 && (mOwn || mBcast) && modeEnable && !mFound) begin
        if (mStage >= 6 && d == addrB(stationAddr, (mStage - 6) % 6)) begin
          mStage++;
          if (mStage == 6 + 96) begin
            det = 1; mFound = 1; mStage = 0;
          end
        end else if (d == 8'hFF) begin
          if (mStage < 6) mStage++;
          else if (mStage > 6) mStage = 1;
        end else begin
          mStage = 0;
        end
      end
      mIdx++;
    end
    if (v) begin
      if (e) mInFrame = 0;
      else if (s) mInFrame = 1;
    end
    if (det) expStatus = 1;
    else if (clr) expStatus = 0;
  endtask

  // Drive at a falling edge, predict, then compare at the next falling edge.
  task automatic step(input bit v, input logic [7:0] d, input bit s, input bit e, input bit clr);
    rxValid = v; rxData = d; rxSof = s; rxEof = e; statusClear = clr;
    modelByte(v, d, s, e, clr);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0);
  endtask

  task automatic clearStatus();
    step(0, 8'h00, 0, 0, 1);
  endtask

  task automatic pushAddr(input logic [47:0] a);
    for (int i = 0; i < 6; i++) frameQ.push_back(addrB(a, i));
  endtask

  task automatic pushMagic(input int nFF, input int nRep, input logic [47:0] a);
    for (int i = 0; i < nFF; i++) frameQ.push_back(8'hFF);
    for (int r = 0; r < nRep; r++) pushAddr(a);
  endtask

  task automatic startFrame(input logic [47:0] dest, input logic [47:0] src);
    frameQ.delete();
    pushAddr(dest);
    pushAddr(src);
  endtask

  // Send frameQ; clearAtLast raises statusClear with the final byte.
  task automatic sendFrame(input bit clearAtLast);
    int n = frameQ.size();
    for (int i = 0; i < n; i++)
      step(1, frameQ[i], i == 0, i == n - 1, clearAtLast && (i == n - 1));
    idle(2);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] other = 48'h0A0B0C0D0E0F;
    logic [47:0] srcA  = 48'h123456789ABC;
    logic [47:0] rev   = 48'h112233445566;
    repeat (3) @(negedge clk);
    check("R8", "status after reset", wakeStatus, 1'b0);
    check("R1", "rxBlock after reset", rxBlock, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    idle(2);

    // R10: mode off, a correct wake frame is not detected
    startFrame(stationAddr, srcA); frameQ.push_back(8'h42); pushMagic(6, 16, stationAddr); frameQ.push_back(8'h00);
    sendFrame(0);
    check("R10", "no detect while mode off", wakeStatus, 1'b0);

    // R1 and R4: mode on, own destination, long sync run, 16 repeats
    modeEnable = 1; idle(1);
    check("R1", "rxBlock with mode on", rxBlock, 1'b1);
    startFrame(stationAddr, srcA); frameQ.push_back(8'h01); pushMagic(8, 16, stationAddr); frameQ.push_back(8'h77);
    sendFrame(0);
    check("R4", "detect on own address", wakeStatus, 1'b1);
    check("R9", "irq masked", hostIrq, 1'b0);
    irqEnable = 1; idle(1);
    check("R9", "irq enabled", hostIrq, 1'b1);
    pmeEnable = 1; idle(1);
    check("R9", "pme enabled", pmeEvent, 1'b1);
    irqEnable = 0; idle(3);
    check("R8", "status sticky", wakeStatus, 1'b1);
    clearStatus();
    check("R8", "status cleared", wakeStatus, 1'b0);
    irqEnable = 1;

    // R2: other destination ignored, broadcast accepted
    startFrame(other, srcA); pushMagic(6, 16, stationAddr);
    sendFrame(0);
    check("R2", "foreign destination ignored", wakeStatus, 1'b0);
    startFrame(48'hFFFFFFFFFFFF, srcA); pushMagic(6, 16, stationAddr);
    sendFrame(0);
    check("R2", "broadcast destination accepted", wakeStatus, 1'b1);
    clearStatus();

    // R3: sync hidden in the source field does not count
    startFrame(stationAddr, 48'hFFFFFFFFFFFF); pushMagic(0, 16, stationAddr);
    sendFrame(0);
    check("R3", "header bytes skipped", wakeStatus, 1'b0);

    // R5: short sync, short repeat count
    startFrame(stationAddr, srcA); pushMagic(5, 16, stationAddr);
    sendFrame(0);
    check("R5", "five sync bytes", wakeStatus, 1'b0);
    startFrame(stationAddr, srcA); pushMagic(6, 15, stationAddr); frameQ.push_back(8'h00); pushAddr(stationAddr);
    sendFrame(0);
    check("R5", "fifteen repeats", wakeStatus, 1'b0);

    // R6: break by a 0xFF byte starts a new sync run, search goes on
    startFrame(stationAddr, srcA); pushMagic(6, 3, stationAddr);
    frameQ.push_back(8'h11); frameQ.push_back(8'h22);
    pushMagic(6, 16, stationAddr);
    sendFrame(0);
    check("R6", "breaking 0xFF starts sync", wakeStatus, 1'b1);
    clearStatus();
    startFrame(stationAddr, srcA); pushMagic(6, 2, stationAddr); frameQ.push_back(8'h99);
    pushMagic(6, 16, stationAddr); frameQ.push_back(8'h05);
    sendFrame(0);
    check("R6", "restart after mismatch", wakeStatus, 1'b1);
    clearStatus();

    // R7: reversed byte order does not match
    startFrame(stationAddr, srcA); pushMagic(6, 16, rev);
    sendFrame(0);
    check("R7", "reversed address order", wakeStatus, 1'b0);

    // R8: detect and clear in the same cycle
    startFrame(stationAddr, srcA); pushMagic(6, 16, stationAddr);
    sendFrame(1);
    check("R8", "set wins over clear", wakeStatus, 1'b1);
    clearStatus();

    // R10: bytes without a start mark are ignored
    for (int i = 0; i < 6 + 96; i++) step(1, (i < 6) ? 8'hFF : addrB(stationAddr, (i - 6) % 6), 0, 0, 0);
    idle(2);
    check("R10", "bytes outside frame ignored", wakeStatus, 1'b0);

    // R1: clearing the mode releases the receive path
    modeEnable = 0; idle(1);
    check("R1", "rxBlock with mode off", rxBlock, 1'b0);
    startFrame(stationAddr, srcA); pushMagic(6, 16, stationAddr);
    sendFrame(0);
    check("R10", "mode off again", wakeStatus, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule